// File: doc/BRIEF.md
# Matrix Product Element Engine

This block produces a single entry C[I][J] of the product of two N-by-N integer matrices. All three matrices sit in flat memories in row-major order, so entry (r, c) lives at address r*N + c. A start pulse loads the row index, the column index and the dimension. The engine then finds the row base I*N. It does this by adding I to itself N times, so it needs no multiplier. Next it streams one A address and one B address per cycle to two read ports that return data one cycle later.

The engine multiplies each returned pair and adds the product to a cleared running sum. It makes one write of that sum to C at address I*N + J, then pulses done. In the inner loop the A address moves forward by 1 and the B address by N on each step. The write address is formed once, as the sum of the two starting addresses.

Top module: `matmul_dot_elem`

## Requirements
- R1: While reset is held and after it is released with no start, busy, c_we and done are all low.
- R2: A start seen while idle loads row_i, col_j and dim_n. busy is high from the cycle after that edge up to and including the done cycle, and low in the cycle after done.
- R3: A start seen while busy is ignored: the running operation keeps its indices, timing and result.
- R4: The A read addresses are I*N + k for k = 0 .. N-1, one per cycle, in cycles N+1 .. 2N after the start edge.
- R5: The B read addresses are J + k*N for k = 0 .. N-1, in the same cycles as the matching A addresses.
- R6: The read ports return data one cycle after the address. Each returned pair is multiplied and added in the cycle it arrives, so no cycle is lost between addresses.
- R7: c_we is high for exactly one cycle, 2N+2 cycles after the start edge. In that cycle c_addr = I*N + J and c_wdata = the unsigned sum over k of A[I*N+k]*B[k*N+J].
- R8: done is high for exactly one cycle, the cycle after c_we.
- R9: The sum is 2*DATA_W + NDIM_W bits wide and holds the largest result (every element at its maximum, N at its maximum) without wrapping.
- R10: With N = 1 the engine performs one product and one write, and c_we falls in cycle 4.
- R11: The sum is cleared at every start, so an operation never includes products from an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| row_i | input | NDIM_W | Row index I |
| col_j | input | NDIM_W | Column index J |
| dim_n | input | NDIM_W | Matrix dimension N (1 or more) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| a_addr | output | ADDR_W | Read address to the A memory |
| a_rdata | input | DATA_W | A data, valid one cycle after a_addr |
| b_addr | output | ADDR_W | Read address to the B memory |
| b_rdata | input | DATA_W | B data, valid one cycle after b_addr |
| c_we | output | 1 | Write strobe to the C memory |
| c_addr | output | ADDR_W | Write address to the C memory |
| c_wdata | output | ACC_W | Write data (the sum) |

## Verification
All results are timed from the clock edge that accepts start.
- The read addresses are due in cycles N+1 through 2N.
- The write is due in cycle 2N+2 and done in cycle 2N+3.
- busy covers cycles 1 through 2N+3.

The bench model counts cycles from the accepted edge and predicts the value of every output for each cycle. It samples on the falling edge, after all registers have settled. It checks the addresses only inside the issue window, and checks the write and done at their exact cycles.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE,
        ST_ISSUE,
        ST_DRAIN,
        ST_WRITE,
        ST_DONE
    } mmd_state_e;
endpackage

// File: rtl/mmd_addr_gen.sv
module mmd_addr_gen #(
    parameter int NDIM_W = 4,
    parameter int ADDR_W = 2 * NDIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_clr,
    input  logic              base_add,
    input  logic              base_last,
    input  logic              step,
    input  logic [NDIM_W-1:0] row,
    input  logic [NDIM_W-1:0] col,
    input  logic [NDIM_W-1:0] dim,
    output logic [ADDR_W-1:0] a_addr,
    output logic [ADDR_W-1:0] b_addr,
    output logic [ADDR_W-1:0] c_addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] b;
        logic [ADDR_W-1:0] c;
    } ag_regs_t;

    ag_regs_t r_d, r_q;
    logic [ADDR_W-1:0] a_next;

    always_comb begin
        r_d    = r_q;
        a_next = r_q.a + ADDR_W'(row);
        if (base_clr) begin
            r_d.a = '0;
        end else if (base_add) begin
            // row base built as N repeated additions of I
            r_d.a = a_next;
            if (base_last) begin
                r_d.b = ADDR_W'(col);
                r_d.c = a_next + ADDR_W'(col);
            end
        end else if (step) begin
            r_d.a = r_q.a + ADDR_W'(1);
            r_d.b = r_q.b + ADDR_W'(dim);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign a_addr = r_q.a;
    assign b_addr = r_q.b;
    assign c_addr = r_q.c;

    // R4
    a_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (r_q.a == ADDR_W'($past(r_q.a) + ADDR_W'(1))));
    // R5
    b_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (r_q.b == ADDR_W'($past(r_q.b) + ADDR_W'($past(dim)))));
endmodule

// File: rtl/mmd_mac.sv
module mmd_mac #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              issue,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [ACC_W-1:0]  acc
);
    typedef struct packed {
        logic             vld;
        logic [ACC_W-1:0] sum;
    } mac_regs_t;

    mac_regs_t r_d, r_q;
    logic [ACC_W-1:0] prod;

    always_comb begin
        prod    = ACC_W'(a_in) * ACC_W'(b_in);
        r_d     = r_q;
        r_d.vld = issue;
        if (clr)          r_d.sum = '0;
        else if (r_q.vld) r_d.sum = r_q.sum + prod;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign acc = r_q.sum;

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.vld && !clr) |=> (r_q.sum >= $past(r_q.sum)));
endmodule

// File: rtl/matmul_dot_elem.sv
module matmul_dot_elem
    import mmd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NDIM_W = 4,
    parameter int ADDR_W = 2 * NDIM_W,
    parameter int ACC_W  = 2 * DATA_W + NDIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NDIM_W-1:0] row_i,
    input  logic [NDIM_W-1:0] col_j,
    input  logic [NDIM_W-1:0] dim_n,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_rdata,
    output logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_rdata,
    output logic              c_we,
    output logic [ADDR_W-1:0] c_addr,
    output logic [ACC_W-1:0]  c_wdata
);
    typedef struct packed {
        mmd_state_e        st;
        logic [NDIM_W-1:0] cnt;
        logic [NDIM_W-1:0] row;
        logic [NDIM_W-1:0] col;
        logic [NDIM_W-1:0] dim;
    } top_regs_t;

    top_regs_t r_d, r_q;
    logic base_clr, base_add, base_last, step, acc_clr;
    logic last_cnt;

    always_comb begin
        r_d       = r_q;
        base_clr  = 1'b0;
        base_add  = 1'b0;
        base_last = 1'b0;
        step      = 1'b0;
        acc_clr   = 1'b0;
        last_cnt  = (r_q.cnt == r_q.dim - NDIM_W'(1));
        unique case (r_q.st)
            ST_IDLE: if (start) begin
                r_d.row  = row_i;
                r_d.col  = col_j;
                r_d.dim  = dim_n;
                r_d.cnt  = '0;
                r_d.st   = ST_BASE;
                base_clr = 1'b1;
                acc_clr  = 1'b1;
            end
            ST_BASE: begin
                base_add = 1'b1;
                if (last_cnt) begin
                    base_last = 1'b1;
                    r_d.cnt   = '0;
                    r_d.st    = ST_ISSUE;
                end else begin
                    r_d.cnt = r_q.cnt + NDIM_W'(1);
                end
            end
            ST_ISSUE: begin
                step = 1'b1;
                if (last_cnt) r_d.st  = ST_DRAIN;
                else          r_d.cnt = r_q.cnt + NDIM_W'(1);
            end
            ST_DRAIN: r_d.st = ST_WRITE;
            ST_WRITE: r_d.st = ST_DONE;
            ST_DONE:  r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    mmd_addr_gen #(.NDIM_W(NDIM_W), .ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .base_clr(base_clr), .base_add(base_add),
        .base_last(base_last), .step(step), .row(r_q.row), .col(r_q.col),
        .dim(r_q.dim), .a_addr(a_addr), .b_addr(b_addr), .c_addr(c_addr)
    );

    mmd_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .issue(step),
        .a_in(a_rdata), .b_in(b_rdata), .acc(c_wdata)
    );

    assign busy = (r_q.st != ST_IDLE);
    assign c_we = (r_q.st == ST_WRITE);
    assign done = (r_q.st == ST_DONE);

    // R7
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |=> !c_we);
    // R8
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |=> done);
    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R3
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(r_q.row) && $stable(r_q.col) && $stable(r_q.dim)));
    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({c_we, done}));
endmodule

// File: tb/matmul_dot_elem_tb.sv
module matmul_dot_elem_tb;
    localparam int DW = 8;
    localparam int NW = 4;
    localparam int AW = 2 * NW;
    localparam int CW = 2 * DW + NW;
    localparam int MEMSZ = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NW-1:0] row_i = '0, col_j = '0, dim_n = '0;
    logic busy, done, c_we;
    logic [AW-1:0] a_addr, b_addr, c_addr;
    logic [DW-1:0] a_rdata, b_rdata;
    logic [CW-1:0] c_wdata;

    logic [DW-1:0] mem_a [MEMSZ];
    logic [DW-1:0] mem_b [MEMSZ];

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    matmul_dot_elem #(.DATA_W(DW), .NDIM_W(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .row_i(row_i), .col_j(col_j),
        .dim_n(dim_n), .busy(busy), .done(done), .a_addr(a_addr), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_rdata(b_rdata), .c_we(c_we), .c_addr(c_addr),
        .c_wdata(c_wdata)
    );

    always @(posedge clk) begin
        a_rdata <= mem_a[a_addr];
        b_rdata <= mem_b[b_addr];
    end

    function automatic longint dot(int i, int j, int n);
        longint s = 0;
        for (int k = 0; k < n; k++)
            s += longint'(mem_a[(i*n + k) % MEMSZ]) * longint'(mem_b[(k*n + j) % MEMSZ]);
        return s;
    endfunction

    // reference: cycles since accepted start, -1 when idle
    int ref_t = -1;
    int r_i = 0, r_j = 0, r_n = 1;
    longint r_sum = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ref_t <= -1;
        end else if (ref_t < 0) begin
            if (start) begin
                ref_t <= 1;
                r_i   <= int'(row_i);
                r_j   <= int'(col_j);
                r_n   <= int'(dim_n);
                r_sum <= dot(int'(row_i), int'(col_j), int'(dim_n));
            end
        end else if (ref_t >= 2*r_n + 3) begin
            ref_t <= -1;
        end else begin
            ref_t <= ref_t + 1;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", req, ref_t, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            // R2 busy window
            chk("R2 busy", longint'(busy), longint'(ref_t >= 1));
            // R8 done pulse
            chk("R8 done", longint'(done), longint'(ref_t == 2*r_n + 3));
            // R7 write strobe timing
            chk("R7 c_we", longint'(c_we), longint'(ref_t == 2*r_n + 2));
            if (ref_t == 2*r_n + 2) begin
                chk("R7 c_addr", longint'(c_addr), longint'(r_i*r_n + r_j));
                chk("R7 c_wdata", longint'(c_wdata), r_sum);
            end
            if (ref_t >= r_n + 1 && ref_t <= 2*r_n) begin
                // R4 R5 R6 one address pair per cycle
                chk("R4 a_addr", longint'(a_addr), longint'((r_i*r_n + ref_t - r_n - 1) % MEMSZ));
                chk("R5 b_addr", longint'(b_addr), longint'((r_j + (ref_t - r_n - 1)*r_n) % MEMSZ));
            end
        end
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run_op(input int i, input int j, input int n);
        @(negedge clk);
        start = 1'b1;
        row_i = NW'(i); col_j = NW'(j); dim_n = NW'(n);
        @(negedge clk);
        start = 1'b0;
        repeat (2*n + 4) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < MEMSZ; k++) begin
            mem_a[k] = DW'(k*7 + 3);
            mem_b[k] = DW'(k*13 + 5);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", longint'(busy), 0);
        chk("R1 c_we", longint'(c_we), 0);
        chk("R1 done", longint'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle busy", longint'(busy), 0);

        run_op(2, 3, 4);     // R4 R5 R7 basic
        run_op(0, 0, 1);     // R10 single product
        run_op(3, 1, 1);     // R10
        run_op(5, 6, 7);     // R6

        // R3 start while busy ignored
        @(negedge clk);
        start = 1'b1; row_i = 4'd1; col_j = 4'd2; dim_n = 4'd5;
        @(negedge clk);
        start = 1'b1; row_i = 4'd9; col_j = 4'd9; dim_n = 4'd12;
        repeat (4) @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);

        // R11 back-to-back with start held high: sum re-cleared each time
        @(negedge clk);
        start = 1'b1; row_i = 4'd2; col_j = 4'd0; dim_n = 4'd3;
        repeat (2*3 + 6) @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);

        // R9 largest sum
        for (int k = 0; k < MEMSZ; k++) begin
            mem_a[k] = '1;
            mem_b[k] = '1;
        end
        run_op(14, 14, 15);
        run_op(0, 15, 15);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule